// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits on the host side of a bridge and turns CPU I/O accesses into PCI configuration cycles. Software first writes a 32-bit selector through one I/O port. That selector names a bus, a device, a function and a dword register. A later access through a second I/O port acts as a window onto the four configuration bytes that the selector points at. The block turns that access into an address phase on the AD bus and hands it to a separate bus-cycle engine. It then returns the read data to the CPU, or all-ones when the target cannot answer.

On bus 0, the device number is decoded one-hot onto the upper AD lines, which serve as IDSEL lines. Devices 0 and 1 are the bridge's own functions. They are served from small local register banks and never reach the bus. Device numbers above 20 have no IDSEL line, so they end in a master abort. A non-zero bus number produces a Type 1 address phase, which bridges further down the hierarchy forward.

Both data paths use valid/ready. The CPU raises `cpu_valid` and holds its request stable until `cpu_ready` is high for one cycle. That cycle is the completion, and read data is valid in it. Toward the engine, `bus_valid` and every `bus_*` field stay stable until the engine answers with `bus_done` for one cycle. The engine may stall the block for any number of cycles this way. The sticky abort flag `ma_status` and its clear input `ma_clear` are plain control pins.

Top module: `cfgx_bridge`

## Requirements
- R1: After reset the selector reads 0, `ma_status` is 0, and both `cpu_ready` and `bus_valid` are low.
- R2: The selector port (I/O 0xCF8) loads only on a write with all four byte enables set. The layout is: bit 31 enable, bus [23:16], device [15:11], function [10:8] and dword index [7:2]. Reads return bits [30:24] and [1:0] as 0. A write with partial byte enables leaves the selector unchanged.
- R3: While selector bit 31 is 0, an access to the data window (I/O 0xCFC) starts no bus cycle. A read returns 0xFFFFFFFF, and a write has no effect.
- R4: With bus 0 and device 2..20, the address phase has exactly one of AD[31:13] set, at bit device+11. AD[12:11] are 0, AD[10:8] carry the function, AD[7:2] carry the dword index, and AD[1:0] are 00.
- R5: With a non-zero bus number, the address phase equals selector bits [23:2] in AD[23:2], with AD[1:0]=01 and AD[31:24]=0.
- R6: Bus 0 devices 0 and 1 are served from separate local banks without any bus cycle. Writes honour the byte enables, and a read returns the stored dword.
- R7: Bus 0 devices 21..31 produce a Type 0 phase with AD[31:11] all 0. A read returns 0xFFFFFFFF whatever the engine returns, and `ma_status` is set.
- R8: When the engine ends a cycle with `bus_abort`=1, a read returns 0xFFFFFFFF and `ma_status` is set.
- R9: `ma_status` stays 1 until a cycle with `ma_clear`=1 that sets no new abort. A new abort wins over a clear in the same cycle.
- R10: The CPU byte enables, write data and direction pass to the bus unchanged. Bus fields hold steady until `bus_done`. `cpu_ready` rises only after `bus_done`, and a non-aborted read returns `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU I/O request valid |
| cpu_ready | output | 1 | Request complete; read data valid |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | I/O port address |
| cpu_be | input | 4 | Byte enables |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data |
| bus_valid | output | 1 | Configuration cycle request to engine |
| bus_done | input | 1 | Engine completion (ready) |
| bus_write | output | 1 | Configuration write |
| bus_ad | output | 32 | Address phase value |
| bus_be | output | 4 | Byte enables for the data phase |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data from engine |
| bus_abort | input | 1 | Engine reports master abort |
| ma_status | output | 1 | Sticky master-abort flag |
| ma_clear | input | 1 | Clears `ma_status` |

## Verification
Selectors for devices 2, 5 and 20 on bus 0 check that the IDSEL bit is placed at each end of its range and in the middle. Device 21 then separates the missing-IDSEL path from an ordinary Type 0 cycle. Bus numbers 3 and 255 show that Type 1 encoding ignores the device range and keeps bits above 23 clear. Local devices 0 and 1, partial byte-enable writes and a disabled selector show which accesses must stay off the bus. An engine-reported abort, set against a no-IDSEL abort, separates the two ways the sticky flag can be set.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_sel_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RESP} cfg_state_t;

  function automatic logic [31:0] sel_to_word(cfg_sel_t s);
    return {s.en, 7'b0, s.bus, s.dev, s.fn, s.dw, 2'b00};
  endfunction

  function automatic cfg_sel_t word_to_sel(logic [31:0] w);
    cfg_sel_t s;
    s.en  = w[31];
    s.bus = w[23:16];
    s.dev = w[15:11];
    s.fn  = w[10:8];
    s.dw  = w[7:2];
    return s;
  endfunction

endpackage

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] wdata,
  output cfg_sel_t    sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sel <= '0;
    else if (load) sel <= word_to_sel(wdata);
  end
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
#(
  parameter int IDSEL_BASE = 11,
  parameter int LOCAL_DEVS = 2
) (
  input  cfg_sel_t    sel,
  output logic [31:0] ad,
  output logic        is_local,
  output logic        no_idsel
);
  localparam int IDSEL_W = 32 - IDSEL_BASE;
  localparam int MAX_DEV = IDSEL_W - 1;

  logic [IDSEL_W-1:0] idsel;
  logic               type1;

  genvar g;
  generate
    for (g = 0; g < IDSEL_W; g++) begin : g_idsel
      if (g < LOCAL_DEVS) begin : g_local
        assign idsel[g] = 1'b0;
      end else begin : g_line
        assign idsel[g] = (sel.dev == 5'(g));
      end
    end
  endgenerate

  assign type1    = (sel.bus != 8'h00);
  assign is_local = !type1 && (32'(sel.dev) < LOCAL_DEVS);
  assign no_idsel = !type1 && (32'(sel.dev) > MAX_DEV);

  always_comb begin
    if (type1) ad = {8'h00, sel.bus, sel.dev, sel.fn, sel.dw, 2'b01};
    else       ad = {idsel, sel.fn, sel.dw, 2'b00};
  end
endmodule

// File: rtl/cfgx_local_bank.sv
module cfgx_local_bank #(
  parameter int NDEV   = 2,
  parameter int NWORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [4:0]  dev,
  input  logic [2:0]  fn,
  input  logic [5:0]  dw,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int DIW = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int WIW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [31:0] mem [NDEV][NWORDS];
  logic        hit;
  logic [DIW-1:0] di;
  logic [WIW-1:0] wi;

  assign hit = (fn == 3'd0) && (32'(dw) < NWORDS) && (32'(dev) < NDEV);
  assign di  = dev[DIW-1:0];
  assign wi  = dw[WIW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < NDEV; d++)
        for (int w = 0; w < NWORDS; w++)
          mem[d][w] <= '0;
    end else if (we && hit) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) mem[di][wi][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  assign rdata = hit ? mem[di][wi] : 32'h0;
endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
  import cfgx_pkg::*;
#(
  parameter logic [15:0] SEL_PORT   = 16'h0CF8,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC,
  parameter int          IDSEL_BASE = 11,
  parameter int          LOCAL_DEVS = 2,
  parameter int          LOCAL_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  output logic        cpu_ready,
  input  logic        cpu_write,
  input  logic [15:0] cpu_addr,
  input  logic [3:0]  cpu_be,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        bus_valid,
  input  logic        bus_done,
  output logic        bus_write,
  output logic [31:0] bus_ad,
  output logic [3:0]  bus_be,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_abort,
  output logic        ma_status,
  input  logic        ma_clear
);
  cfg_state_t  state;
  cfg_sel_t    sel;
  logic [31:0] xl_ad;
  logic        xl_local, xl_noidsel;
  logic [31:0] bank_rd;
  logic        noidsel_q;
  logic        start, hit_sel, hit_data, sel_load, bank_we, go_bus, abort_set;

  assign start    = (state == ST_IDLE) && cpu_valid;
  assign hit_sel  = (cpu_addr[15:2] == SEL_PORT[15:2]);
  assign hit_data = (cpu_addr[15:2] == DATA_PORT[15:2]);
  assign sel_load = start && hit_sel && cpu_write && (cpu_be == 4'hF);
  assign bank_we  = start && hit_data && sel.en && xl_local && cpu_write;
  assign go_bus   = start && hit_data && sel.en && !xl_local;
  assign abort_set = (state == ST_BUS) && bus_done && (bus_abort || noidsel_q);

  cfgx_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .load(sel_load), .wdata(cpu_wdata), .sel(sel)
  );

  cfgx_xlate #(.IDSEL_BASE(IDSEL_BASE), .LOCAL_DEVS(LOCAL_DEVS)) u_xlate (
    .sel(sel), .ad(xl_ad), .is_local(xl_local), .no_idsel(xl_noidsel)
  );

  cfgx_local_bank #(.NDEV(LOCAL_DEVS), .NWORDS(LOCAL_WORDS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .dev(sel.dev), .fn(sel.fn),
    .dw(sel.dw), .be(cpu_be), .wdata(cpu_wdata), .rdata(bank_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cpu_rdata <= '0;
      bus_ad    <= '0;
      bus_be    <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      noidsel_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cpu_valid) begin
          if (go_bus) begin
            bus_ad    <= xl_ad;
            bus_be    <= cpu_be;
            bus_write <= cpu_write;
            bus_wdata <= cpu_wdata;
            noidsel_q <= xl_noidsel;
            state     <= ST_BUS;
          end else begin
            if (hit_sel)                        cpu_rdata <= sel_to_word(sel);
            else if (hit_data && sel.en)        cpu_rdata <= bank_rd;
            else                                cpu_rdata <= '1;
            state <= ST_RESP;
          end
        end
        ST_BUS: if (bus_done) begin
          cpu_rdata <= (bus_abort || noidsel_q) ? '1 : bus_rdata;
          state     <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ma_status <= 1'b0;
    else if (abort_set) ma_status <= 1'b1;
    else if (ma_clear)  ma_status <= 1'b0;
  end

  assign bus_valid = (state == ST_BUS);
  assign cpu_ready = (state == ST_RESP);
endmodule

// File: rtl/cfgx_bridge_chk.sv
module cfgx_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic        cpu_ready,
  input logic        bus_valid,
  input logic        bus_done,
  input logic        bus_write,
  input logic [31:0] bus_ad,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        bus_abort,
  input logic        ma_status,
  input logic        ma_clear
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_done |=> bus_valid && $stable(bus_ad) && $stable(bus_be)
      && $stable(bus_write) && $stable(bus_wdata)); // R10
  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !cpu_ready); // R10
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R10
  AST_ONE_IDSEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ad[1:0] == 2'b00 |-> $onehot0(bus_ad[31:11])
      && bus_ad[12:11] == 2'b00); // R4
  AST_TYPE1_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ad[1:0] == 2'b01 |-> bus_ad[31:24] == 8'h00); // R5
  AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_done && bus_abort |=> ma_status); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ma_status && !ma_clear |=> ma_status); // R9
  AST_READY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid); // R10
endmodule

bind cfgx_bridge cfgx_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .bus_valid(bus_valid), .bus_done(bus_done), .bus_write(bus_write),
  .bus_ad(bus_ad), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_abort(bus_abort), .ma_status(ma_status), .ma_clear(ma_clear)
);

// File: tb/cfgx_bridge_test.sv
module cfgx_bridge_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_valid = 0, cpu_write = 0;
  logic [15:0] cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_valid, bus_write;
  logic        bus_done = 0, bus_abort = 0, ma_clear = 0;
  logic [31:0] bus_ad, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [3:0]  bus_be;
  logic        ma_status;

  int checks = 0, errors = 0, nbus = 0;

  typedef struct {
    string       req;
    logic [31:0] ad;
    logic [3:0]  be;
    logic        wr;
    logic [31:0] wd;
    logic [31:0] rsp;
    logic        abt;
  } bus_item_t;
  bus_item_t sb[$];

  always #4 clk = ~clk;

  cfgx_bridge uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_valid(bus_valid),
    .bus_done(bus_done), .bus_write(bus_write), .bus_ad(bus_ad),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_abort(bus_abort), .ma_status(ma_status), .ma_clear(ma_clear)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_bus(string req, logic [31:0] ad, logic [3:0] be,
                            logic wr, logic [31:0] wd, logic [31:0] rsp,
                            logic abt);
    bus_item_t it;
    it.req = req; it.ad = ad; it.be = be; it.wr = wr; it.wd = wd;
    it.rsp = rsp; it.abt = abt;
    sb.push_back(it);
  endtask

  task automatic access(logic wr, logic [15:0] port, logic [3:0] be,
                        logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = port; cpu_be = be; cpu_wdata = wd;
    do @(negedge clk); while (!cpu_ready);
    rd = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); ma_clear = 1;
    @(negedge clk); ma_clear = 0;
  endtask

  // bus engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_valid) begin
        bus_item_t it;
        nbus++;
        if (sb.size() == 0) begin
          chk("R3 unexpected bus cycle", bus_ad, 32'hx);
        end else begin
          it = sb.pop_front();
          chk({it.req, " ad"}, bus_ad, it.ad);
          chk("R10 be", {28'h0, bus_be}, {28'h0, it.be});
          chk("R10 dir", {31'h0, bus_write}, {31'h0, it.wr});
          if (it.wr) chk("R10 wdata", bus_wdata, it.wd);
          chk("R10 no ready before done", {31'h0, cpu_ready}, 32'h0);
          @(negedge clk);
          @(negedge clk);
          chk("R10 held", bus_ad, it.ad);
          bus_done = 1; bus_rdata = it.rsp; bus_abort = it.abt;
          @(negedge clk);
          bus_done = 0; bus_abort = 0; bus_rdata = '0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n0;
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'h0, cpu_ready}, 32'h0);
    chk("R1 bus_valid", {31'h0, bus_valid}, 32'h0);
    chk("R1 ma_status", {31'h0, ma_status}, 32'h0);
    rst_n = 1;
    access(0, 16'h0CF8, 4'hF, 0, rd);
    chk("R1 selector", rd, 32'h0);

    // R2 load with stray bits, readback masked
    access(1, 16'h0CF8, 4'hF, 32'h80002A0C | 32'h7F000003, rd);
    access(0, 16'h0CF8, 4'hF, 0, rd);
    chk("R2 masked readback", rd, 32'h80002A0C);
    access(1, 16'h0CF8, 4'h3, 32'h0, rd);
    access(0, 16'h0CF8, 4'hF, 0, rd);
    chk("R2 partial write ignored", rd, 32'h80002A0C);

    // R4 device 5, fn 2, dw 3; read and write
    expect_bus("R4 dev5", 32'h0001020C, 4'hF, 0, 0, 32'h12345678, 0);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R10 read data", rd, 32'h12345678);
    expect_bus("R10 write", 32'h0001020C, 4'h5, 1, 32'hAABBCCDD, 0, 0);
    access(1, 16'h0CFC, 4'h5, 32'hAABBCCDD, rd);

    // R4 boundaries
    access(1, 16'h0CF8, 4'hF, 32'h80001000, rd);
    expect_bus("R4 dev2 AD13", 32'h00002000, 4'hF, 0, 0, 32'h1, 0);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    access(1, 16'h0CF8, 4'hF, 32'h8000A000, rd);
    expect_bus("R4 dev20 AD31", 32'h80000000, 4'hF, 0, 0, 32'h2, 0);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R4 dev20 data", rd, 32'h2);

    // R5 type 1
    access(1, 16'h0CF8, 4'hF, 32'h800339FC, rd);
    expect_bus("R5 bus3", 32'h000339FD, 4'hF, 0, 0, 32'h33, 0);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    access(1, 16'h0CF8, 4'hF, 32'h80FFF800, rd);
    expect_bus("R5 bus255 dev31", 32'h00FFF801, 4'hF, 0, 0, 32'h44, 0);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R5 data", rd, 32'h44);
    chk("R5 no abort", {31'h0, ma_status}, 32'h0);

    // R7 device 21, no IDSEL
    access(1, 16'h0CF8, 4'hF, 32'h8000A800, rd);
    expect_bus("R7 dev21 no idsel", 32'h00000000, 4'hF, 0, 0, 32'h5555, 0);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R7 all ones", rd, 32'hFFFFFFFF);
    chk("R7 flag", {31'h0, ma_status}, 32'h1);
    access(0, 16'h0CF8, 4'hF, 0, rd);
    chk("R9 sticky", {31'h0, ma_status}, 32'h1);
    pulse_clear();
    chk("R9 cleared", {31'h0, ma_status}, 32'h0);

    // R8 engine abort on type 1
    access(1, 16'h0CF8, 4'hF, 32'h80050000, rd);
    expect_bus("R8 abort", 32'h00050001, 4'hF, 0, 0, 32'h1234, 1);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R8 all ones", rd, 32'hFFFFFFFF);
    chk("R8 flag", {31'h0, ma_status}, 32'h1);
    pulse_clear();

    // R3 disabled selector
    access(1, 16'h0CF8, 4'hF, 32'h00002A0C, rd);
    n0 = nbus;
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R3 read ones", rd, 32'hFFFFFFFF);
    access(1, 16'h0CFC, 4'hF, 32'h5A5A5A5A, rd);
    chk("R3 no bus cycle", n0, nbus);

    // R6 local devices
    n0 = nbus;
    access(1, 16'h0CF8, 4'hF, 32'h80000808, rd);
    access(1, 16'h0CFC, 4'h3, 32'h11223344, rd);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R6 dev1 byte write", rd, 32'h00003344);
    access(1, 16'h0CF8, 4'hF, 32'h80000008, rd);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R6 dev0 separate", rd, 32'h0);
    access(1, 16'h0CFC, 4'hF, 32'hCAFEF00D, rd);
    access(0, 16'h0CFC, 4'hF, 0, rd);
    chk("R6 dev0 readback", rd, 32'hCAFEF00D);
    chk("R6 no bus cycle", n0, nbus);

    repeat (4) @(negedge clk);
    chk("R10 scoreboard empty", sb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule